// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block joins two eight-input interrupt resolvers into one sixteen-line interrupt system. Lines 0 to 7 feed the primary resolver and lines 8 to 15 feed the secondary one. Bit 3 of a line's index selects the resolver. The secondary resolver does not drive the CPU directly. Whenever it holds a pending request, it marks input 2 of the primary resolver as pending. The primary resolver's pending state drives the single interrupt line to the CPU.

When the CPU pulses the acknowledge strobe, the block picks the winning request and returns an 8-bit vector number with a one-cycle valid strobe. It then clears the acknowledged request in the primary resolver, and in the secondary resolver too when the primary winner is the cascade input. When the acknowledge finds nothing to serve, it returns a spurious vector built from line 7 of the resolver concerned.

Each line is either edge-triggered or level-triggered. The choice comes from parameters, but a fixed mask per resolver forces some lines to edge mode. The vector is the upper five bits of the chosen base with the 3-bit line number below them.

Top module: `pic_cascade_ack`

## Requirements
- R1: Within each resolver the pending request with the lowest line index wins. Lines 0..7 belong to the primary resolver and lines 8..15 to the secondary resolver (bit 3 of the line index).
- R2: `intOut` is high exactly when the primary resolver has a pending request. It reflects the result of an acknowledge in the cycle after `ackReq`.
- R3: `vecValid` is high for exactly one cycle, the cycle after `ackReq` is sampled high. `vector` is valid in that same cycle.
- R4: If the primary winner is line n with n not equal to 2, the vector is `{priBase[7:3], n}` and an edge-mode request on that line is cleared.
- R5: If the primary winner is input 2 and the secondary resolver has winner m (0..7), the vector is `{secBase[7:3], m}` and both requests are acknowledged.
- R6: Input 2 of the primary resolver becomes pending whenever the secondary resolver has a pending request. It stays pending until acknowledged, even if the secondary request goes away first.
- R7: If the primary winner is input 2 and the secondary resolver has nothing pending, the vector is `{secBase[7:3], 3'd7}` and the secondary state is left unchanged.
- R8: If the primary resolver has nothing pending at acknowledge, the vector is `{priBase[7:3], 3'd7}`.
- R9: Line i is level-triggered when bit i of the trigger-mode value is 1. The trigger-mode value is `{SEC_LEVEL & 8'hDE, PRI_LEVEL & 8'hF8}`; every other line is edge-triggered. An edge-mode line latches pending on a rising edge until acknowledged. A level-mode line is pending exactly while its input is high, and an acknowledge does not clear it.
- R10: External request line 2 has no effect; that input is reserved for the cascade.
- R11: Bits 2..0 of `priBase` and `secBase` have no effect on the vector.
- R12: A rising edge on an edge-mode line in the same cycle as the acknowledge of that line leaves the line pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqLines | input | 16 | Interrupt request lines, bit i is line i |
| ackReq | input | 1 | CPU acknowledge strobe, one cycle per acknowledge |
| priBase | input | 8 | Vector base of the primary resolver |
| secBase | input | 8 | Vector base of the secondary resolver |
| intOut | output | 1 | Interrupt request to the CPU |
| vector | output | 8 | Returned vector number |
| vecValid | output | 1 | One-cycle strobe marking `vector` valid |

## Verification
The hardest state to reach is the spurious acknowledge through the cascade input. In that state the primary resolver still holds input 2 pending while the secondary resolver no longer has any request. The stimulus reaches it in two ways. The first pulses a level-mode secondary line high for a single cycle and then acknowledges. The second acknowledges one of two held secondary level lines and drops both, so input 2 is re-armed by the acknowledge edge and then left without a source. A behavioural reference model follows every cycle, including a long random phase, so that simultaneous edges and acknowledges are compared as well.

// File: rtl/cascade_ack_pkg.sv
`timescale 1ns/1ps
package cascade_ack_pkg;
  localparam int CTRL_LINES  = 8;
  localparam int IDX_W       = $clog2(CTRL_LINES);
  localparam int TOTAL_LINES = 2 * CTRL_LINES;
  localparam int VEC_W       = 8;

  localparam logic [IDX_W-1:0] CASCADE_IDX  = IDX_W'(2);
  localparam logic [IDX_W-1:0] SPURIOUS_IDX = IDX_W'(CTRL_LINES - 1);

  // Fixed trigger-mode masks: zero bits are forced to edge mode
  localparam logic [CTRL_LINES-1:0] PRI_TRIG_MASK = 8'hF8;
  localparam logic [CTRL_LINES-1:0] SEC_TRIG_MASK = 8'hDE;

  localparam logic [VEC_W-1:0] BASE_KEEP = ~VEC_W'((1 << IDX_W) - 1);

  typedef struct packed {
    logic             fire;
    logic             clrPri;
    logic [IDX_W-1:0] priIdx;
    logic             clrSec;
    logic [IDX_W-1:0] secIdx;
    logic             useSecBase;
    logic [IDX_W-1:0] vecIdx;
  } ack_cmd_t;
endpackage

// File: rtl/ack_resolver.sv
`timescale 1ns/1ps
module ack_resolver #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] pend,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/ack_control.sv
`timescale 1ns/1ps
module ack_control
  import cascade_ack_pkg::*;
(
  input  logic             ackReq,
  input  logic             priAny,
  input  logic [IDX_W-1:0] priIdx,
  input  logic             secAny,
  input  logic [IDX_W-1:0] secIdx,
  output ack_cmd_t         cmd
);
  always_comb begin
    cmd        = '0;
    cmd.fire   = ackReq;
    cmd.vecIdx = SPURIOUS_IDX;
    if (ackReq && priAny) begin
      cmd.clrPri = 1'b1;
      cmd.priIdx = priIdx;
      if (priIdx == CASCADE_IDX) begin
        cmd.useSecBase = 1'b1;
        if (secAny) begin
          cmd.clrSec = 1'b1;
          cmd.secIdx = secIdx;
          cmd.vecIdx = secIdx;
        end
      end else begin
        cmd.vecIdx = priIdx;
      end
    end
  end
endmodule

// File: rtl/ack_datapath.sv
`timescale 1ns/1ps
module ack_datapath
  import cascade_ack_pkg::*;
#(
  parameter logic [CTRL_LINES-1:0] PRI_LEVEL = '1,
  parameter logic [CTRL_LINES-1:0] SEC_LEVEL = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TOTAL_LINES-1:0] reqLines,
  input  logic [VEC_W-1:0]       priBase,
  input  logic [VEC_W-1:0]       secBase,
  input  ack_cmd_t               cmd,
  output logic [CTRL_LINES-1:0]  priPend,
  output logic [CTRL_LINES-1:0]  secPend,
  output logic                   intOut,
  output logic [VEC_W-1:0]       vector,
  output logic                   vecValid
);
  localparam logic [CTRL_LINES-1:0] PRI_LVL   = PRI_LEVEL & PRI_TRIG_MASK;
  localparam logic [CTRL_LINES-1:0] SEC_LVL   = SEC_LEVEL & SEC_TRIG_MASK;
  localparam logic [CTRL_LINES-1:0] CASC_BIT  = CTRL_LINES'(1) << CASCADE_IDX;

  logic [CTRL_LINES-1:0] priLine, secLine, priLast, secLast;
  logic [CTRL_LINES-1:0] priClr, secClr, priNext, secNext;
  logic [VEC_W-1:0]      selBase;

  function automatic logic [CTRL_LINES-1:0] nextPend(
    input logic [CTRL_LINES-1:0] q, line, last, clr, lvl);
    return (lvl & line) | (~lvl & ((q & ~clr) | (line & ~last)));
  endfunction

  assign priLine = reqLines[CTRL_LINES-1:0] & ~CASC_BIT;
  assign secLine = reqLines[TOTAL_LINES-1:CTRL_LINES];
  assign priClr  = cmd.clrPri ? (CTRL_LINES'(1) << cmd.priIdx) : '0;
  assign secClr  = cmd.clrSec ? (CTRL_LINES'(1) << cmd.secIdx) : '0;

  assign secNext = nextPend(secPend, secLine, secLast, secClr, SEC_LVL);
  assign priNext = nextPend(priPend, priLine, priLast, priClr, PRI_LVL)
                 | ((|secNext) ? CASC_BIT : '0);

  assign selBase = cmd.useSecBase ? secBase : priBase;
  assign intOut  = |priPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priPend  <= '0;
      secPend  <= '0;
      priLast  <= '0;
      secLast  <= '0;
      vector   <= '0;
      vecValid <= 1'b0;
    end else begin
      priPend  <= priNext;
      secPend  <= secNext;
      priLast  <= priLine;
      secLast  <= secLine;
      vecValid <= cmd.fire;
      if (cmd.fire) vector <= (selBase & BASE_KEEP) | VEC_W'(cmd.vecIdx);
    end
  end
endmodule

// File: rtl/pic_cascade_ack.sv
`timescale 1ns/1ps
module pic_cascade_ack
  import cascade_ack_pkg::*;
#(
  parameter logic [CTRL_LINES-1:0] PRI_LEVEL = '1,
  parameter logic [CTRL_LINES-1:0] SEC_LEVEL = '1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TOTAL_LINES-1:0] reqLines,
  input  logic                   ackReq,
  input  logic [VEC_W-1:0]       priBase,
  input  logic [VEC_W-1:0]       secBase,
  output logic                   intOut,
  output logic [VEC_W-1:0]       vector,
  output logic                   vecValid
);
  logic [CTRL_LINES-1:0]       priPend, secPend;
  logic [1:0][CTRL_LINES-1:0]  bankPend;
  logic [1:0]                  bankAny;
  logic [1:0][IDX_W-1:0]       bankIdx;
  ack_cmd_t                    cmd;

  assign bankPend = {secPend, priPend};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ack_resolver #(.N(CTRL_LINES)) u_res (
      .pend(bankPend[b]),
      .any (bankAny[b]),
      .idx (bankIdx[b])
    );
  end

  ack_control u_ctl (
    .ackReq(ackReq),
    .priAny(bankAny[0]),
    .priIdx(bankIdx[0]),
    .secAny(bankAny[1]),
    .secIdx(bankIdx[1]),
    .cmd   (cmd)
  );

  ack_datapath #(.PRI_LEVEL(PRI_LEVEL), .SEC_LEVEL(SEC_LEVEL)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqLines(reqLines),
    .priBase (priBase),
    .secBase (secBase),
    .cmd     (cmd),
    .priPend (priPend),
    .secPend (secPend),
    .intOut  (intOut),
    .vector  (vector),
    .vecValid(vecValid)
  );
endmodule

// File: rtl/pic_cascade_ack_chk.sv
`timescale 1ns/1ps
module pic_cascade_ack_chk
  import cascade_ack_pkg::*;
#(
  parameter logic [CTRL_LINES-1:0] PRI_LEVEL = '1,
  parameter logic [CTRL_LINES-1:0] SEC_LEVEL = '1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [TOTAL_LINES-1:0] reqLines,
  input logic                   ackReq,
  input logic [VEC_W-1:0]       priBase,
  input logic                   intOut,
  input logic [VEC_W-1:0]       vector,
  input logic                   vecValid,
  input logic [CTRL_LINES-1:0]  priPend,
  input logic [CTRL_LINES-1:0]  secPend
);
  localparam logic [TOTAL_LINES-1:0] LVL_ALL =
    {SEC_LEVEL & SEC_TRIG_MASK, PRI_LEVEL & PRI_TRIG_MASK};

  assert_valid_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> vecValid);

  assert_valid_only_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !vecValid);

  assert_spurious_primary_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !intOut) |=>
      (vector == (($past(priBase) & BASE_KEEP) | VEC_W'(SPURIOUS_IDX))));

  assert_cascade_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|secPend) |-> priPend[CASCADE_IDX]);

  assert_cascade_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(priPend[CASCADE_IDX]) |-> (|secPend));

  assert_level_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (({secPend, priPend} & LVL_ALL) == ($past(reqLines) & LVL_ALL)));
endmodule

bind pic_cascade_ack pic_cascade_ack_chk #(.PRI_LEVEL(PRI_LEVEL), .SEC_LEVEL(SEC_LEVEL)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqLines(reqLines),
  .ackReq  (ackReq),
  .priBase (priBase),
  .intOut  (intOut),
  .vector  (vector),
  .vecValid(vecValid),
  .priPend (priPend),
  .secPend (secPend)
);

// File: tb/sim_pic_cascade_ack.sv
`timescale 1ns/1ps
module sim_pic_cascade_ack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqLines = '0;
  logic        ackReq = 1'b0;
  logic [7:0]  priBase = 8'h20;
  logic [7:0]  secBase = 8'h70;
  logic        intOut;
  logic [7:0]  vector;
  logic        vecValid;

  int checks = 0;
  int errors = 0;

  // default parameters: all lines requested level, masks F8 / DE apply
  localparam bit [15:0] LVL = 16'hDEF8;

  always #2.5 clk = ~clk;

  pic_cascade_ack u0 (
    .clk(clk), .rstN(rstN), .reqLines(reqLines), .ackReq(ackReq),
    .priBase(priBase), .secBase(secBase),
    .intOut(intOut), .vector(vector), .vecValid(vecValid)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit [15:0] mPend, mLast;
  bit        mValid;
  int        mVec;

  always @(posedge clk) begin
    bit [15:0] clr, nxt;
    int pw, sw, v;
    if (!rstN) begin
      mPend = '0; mLast = '0; mValid = 0; mVec = 0;
    end else begin
      pw = -1; sw = -1; clr = '0; v = 0;
      for (int i = 7; i >= 0; i--) if (mPend[i]) pw = i;
      for (int i = 15; i >= 8; i--) if (mPend[i]) sw = i - 8;
      if (ackReq) begin
        if (pw < 0) v = (priBase & 8'hF8) + 7;
        else if (pw != 2) begin v = (priBase & 8'hF8) + pw; clr[pw] = 1; end
        else begin
          clr[2] = 1;
          if (sw >= 0) begin v = (secBase & 8'hF8) + sw; clr[sw + 8] = 1; end
          else v = (secBase & 8'hF8) + 7;
        end
        mVec = v;
      end
      mValid = ackReq;
      nxt = '0;
      for (int i = 0; i < 16; i++) begin
        if (i == 2) continue;
        if (LVL[i]) nxt[i] = reqLines[i];
        else nxt[i] = (mPend[i] & ~clr[i]) | (reqLines[i] & ~mLast[i]);
      end
      nxt[2] = (mPend[2] & ~clr[2]) | (|nxt[15:8]);
      mLast = reqLines;
      mPend = nxt;
    end
  end

  always @(negedge clk) begin
    check("R2 model intOut", int'(intOut), int'(|mPend[7:0]));
    check("R3 model vecValid", int'(vecValid), int'(mValid));
    if (mValid) check("R4 model vector", int'(vector), mVec);
  end

  task automatic doAck();
    ackReq = 1'b1;
    @(negedge clk);
    ackReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset intOut", int'(intOut), 0);
    check("R3 reset vecValid", int'(vecValid), 0);

    // R4 / R9: edge line latches, primary acknowledge
    reqLines[1] = 1; @(negedge clk);
    check("R9 edge latch", int'(intOut), 1);
    reqLines[1] = 0; @(negedge clk);
    check("R9 edge held after drop", int'(intOut), 1);
    doAck();
    check("R3 valid after ack", int'(vecValid), 1);
    check("R4 primary vector", int'(vector), 'h21);
    check("R2 intOut after ack", int'(intOut), 0);
    @(negedge clk);
    check("R3 valid single cycle", int'(vecValid), 0);

    // R1: lowest index wins; R9 level line survives ack
    reqLines[1] = 1; reqLines[5] = 1; @(negedge clk);
    doAck();
    check("R1 primary priority", int'(vector), 'h21);
    doAck();
    check("R9 level vector", int'(vector), 'h25);
    check("R9 level not cleared", int'(intOut), 1);
    reqLines[1] = 0; reqLines[5] = 0; @(negedge clk);
    check("R9 level follows input", int'(intOut), 0);

    // R5 / R6: cascaded acknowledge
    reqLines[8] = 1; @(negedge clk);
    check("R6 cascade raises intOut", int'(intOut), 1);
    doAck();
    check("R5 cascaded vector", int'(vector), 'h70);
    check("R5 both cleared", int'(intOut), 0);
    reqLines[8] = 0;

    // R7: secondary request vanishes before acknowledge
    reqLines[9] = 1; @(negedge clk);
    reqLines[9] = 0; @(negedge clk);
    check("R6 cascade input held", int'(intOut), 1);
    doAck();
    check("R7 secondary spurious", int'(vector), 'h77);
    check("R7 intOut after spurious", int'(intOut), 0);

    // R8: nothing pending
    doAck();
    check("R8 primary spurious", int'(vector), 'h27);
    check("R8 intOut stays low", int'(intOut), 0);

    // R10: external line 2 ignored
    reqLines[2] = 1; repeat (2) @(negedge clk);
    check("R10 line 2 ignored", int'(intOut), 0);
    reqLines[2] = 0;

    // R12: new edge in the acknowledge cycle
    reqLines[0] = 1; @(negedge clk);
    reqLines[0] = 0; @(negedge clk);
    reqLines[0] = 1; doAck();
    check("R12 ack vector", int'(vector), 'h20);
    check("R12 edge kept pending", int'(intOut), 1);
    doAck();
    check("R9 forced edge on line 0", int'(intOut), 0);
    reqLines[0] = 0;

    // R11: base low bits ignored; R9 mask on line 13
    priBase = 8'h27; secBase = 8'h75;
    reqLines[13] = 1; @(negedge clk);
    doAck();
    check("R11 base low bits", int'(vector), 'h75);
    check("R9 forced edge on line 13", int'(intOut), 0);
    reqLines[13] = 0;

    // R1 secondary priority, then R7 spurious via re-armed cascade input
    reqLines[12] = 1; reqLines[10] = 1; @(negedge clk);
    doAck();
    check("R1 secondary priority", int'(vector), 'h72);
    reqLines[12] = 0; reqLines[10] = 0; @(negedge clk);
    check("R6 cascade re-armed", int'(intOut), 1);
    doAck();
    check("R7 spurious after drop", int'(vector), 'h77);

    // random phase against the model
    for (int n = 0; n < 2000; n++) begin
      reqLines = reqLines ^ 16'($urandom & $urandom);
      ackReq = (($urandom % 4) == 0);
      priBase = 8'($urandom);
      secBase = 8'($urandom);
      @(negedge clk);
    end
    ackReq = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule